// File: doc/BRIEF.md
# Big-Endian Sub-Word RAM Port

A word-organised memory of 32-bit entries reached through a byte-addressed port that accepts byte, halfword and word reads and writes. Byte 0 of each word occupies the most significant lane. Reads return the selected lane right-justified and zero-extended. Byte and halfword writes change only the addressed lane and keep the rest of the stored word.

A separate debug mode performs word-granular accesses with argument checking. A misaligned offset is rejected as an argument error. An aligned offset past the end of the array is rejected as nonexistent memory. A rejected access writes nothing and reads zero. All contents clear to zero on reset. Results appear on registered outputs one cycle after the request.

Top module: `be_subword_ram`

## Requirements
- R1: The word index is the byte offset shifted right by two; accesses to different words never disturb each other.
- R2: Size code 2'b00 (byte) places offset low bits 0,1,2,3 on word bits 31:24, 23:16, 15:8, 7:0; a read returns that byte zero-extended in rdata_o[7:0].
- R3: Size code 2'b01 (halfword) selects word bits 31:16 when offset bit 1 is clear and 15:0 when it is set; offset bit 0 is ignored; read data is zero-extended.
- R4: A byte or halfword write replaces only the selected lane, keeps all other word bits, and ignores write data bits above the lane width.
- R5: Size code 2'b10 (word) reads or writes the whole word; on a normal (non-debug) access the low two offset bits are ignored.
- R6: A debug access (dbg_i=1, always word-granular) whose offset has either low bit set raises err_arg_o for one cycle, writes nothing and reads zero; this takes priority over the range check.
- R7: An aligned debug access at offset DEPTH*4 or beyond raises err_nxm_o for one cycle, writes nothing and reads zero; err_arg_o and err_nxm_o are never high together.
- R8: Reset clears every word and all outputs to zero.
- R9: Size code 2'b11 is unsupported: a read returns zero and a write leaves memory unchanged.
- R10: rdata_o and the error flags update on the clock edge that samples req_i. rdata_o holds its value through idle cycles and writes. A normal access beyond the array reads zero, writes nothing and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| dbg_i | input | 1 | Word-granular checked debug access |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 unsupported |
| offs_i | input | OFFS_W | Byte offset from the block base |
| wdata_i | input | 32 | Write data, right-justified |
| rdata_o | output | 32 | Read data, right-justified, zero-extended |
| err_arg_o | output | 1 | Debug access was misaligned |
| err_nxm_o | output | 1 | Debug access was out of range |

## Verification
The bench writes known words and reads back every byte and both halfword positions. A design with little-endian lane placement, or one that does not ignore offset bit 0 on halfwords, would return swapped lanes. Partial writes carry all-ones in their unused upper data bits, so a design that misses the merge or the lane masking would corrupt neighbouring bytes. Debug accesses cover a misaligned in-range offset, an aligned out-of-range offset and an offset that is both, so a wrong flag priority or a rejected access that still writes shows up on the flags or in a later readback. Unsupported size codes and normal out-of-range accesses are checked to leave memory untouched and to read zero.

// File: rtl/be_ram_pkg.sv
package be_ram_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } size_e;
endpackage

// File: rtl/be_lane_decode.sv
module be_lane_decode
  import be_ram_pkg::*;
(
  input  size_e       size_i,
  input  logic [1:0]  low_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rword_i,
  output logic [31:0] mask_o,
  output logic [31:0] wpos_o,
  output logic [31:0] rext_o
);
  logic [31:0] base;
  logic [4:0]  shift;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin base = 32'h0000_00ff; shift = {~low_i, 3'b000}; end
      SZ_HALF: begin base = 32'h0000_ffff; shift = low_i[1] ? 5'd0 : 5'd16; end
      SZ_WORD: begin base = 32'hffff_ffff; shift = 5'd0; end
      default: begin base = 32'h0;         shift = 5'd0; end
    endcase
    mask_o = base << shift;
    wpos_o = (wdata_i & base) << shift;
    rext_o = (rword_i & mask_o) >> shift;
  end

  always_comb begin
    if (!$isunknown(size_i)) begin
      if (size_i == SZ_BYTE)
        p_byte_width_r2: assert ($countones(mask_o) == 8);
      if (size_i == SZ_NONE)
        p_none_empty_r9: assert (mask_o == 32'h0 && rext_o == 32'h0);
    end
  end
endmodule

// File: rtl/be_access_check.sv
module be_access_check #(
  parameter int OFFS_W = 10,
  parameter int DEPTH  = 64
) (
  input  logic              dbg_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic              in_range_o,
  output logic              arg_bad_o,
  output logic              nxm_bad_o
);
  localparam int WIDX_W = OFFS_W - 2;
  logic [WIDX_W-1:0] widx;

  assign widx       = offs_i[OFFS_W-1:2];
  assign in_range_o = (32'(widx) < 32'(DEPTH));
  // alignment is judged before range
  assign arg_bad_o  = dbg_i && (offs_i[1:0] != 2'b00);
  assign nxm_bad_o  = dbg_i && !arg_bad_o && !in_range_o;
endmodule

// File: rtl/be_ram_array.sv
module be_ram_array #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      mask_i,
  input  logic [31:0]      wpos_i,
  output logic [31:0]      rword_o
);
  logic [31:0] mem [DEPTH];

  assign rword_o = mem[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[idx_i] <= (mem[idx_i] & ~mask_i) | (wpos_i & mask_i);
    end
  end

  p_merge_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem[$past(idx_i)] & ~$past(mask_i)) == ($past(rword_o) & ~$past(mask_i))));
endmodule

// File: rtl/be_subword_ram.sv
module be_subword_ram
  import be_ram_pkg::*;
#(
  parameter int OFFS_W = 10,
  parameter int DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              dbg_i,
  input  logic [1:0]        size_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_arg_o,
  output logic              err_nxm_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic        in_range, arg_bad, nxm_bad, acc_ok;
  size_e       eff_size;
  logic [31:0] mask, wpos, rext, rword;
  logic [IDX_W-1:0] idx;

  assign eff_size = dbg_i ? SZ_WORD : size_e'(size_i);
  assign idx      = offs_i[IDX_W+1:2];

  be_access_check #(.OFFS_W(OFFS_W), .DEPTH(DEPTH)) i_check (
    .dbg_i(dbg_i), .offs_i(offs_i),
    .in_range_o(in_range), .arg_bad_o(arg_bad), .nxm_bad_o(nxm_bad)
  );

  be_lane_decode i_lane (
    .size_i(eff_size), .low_i(offs_i[1:0]), .wdata_i(wdata_i),
    .rword_i(rword), .mask_o(mask), .wpos_o(wpos), .rext_o(rext)
  );

  assign acc_ok = req_i && in_range && !arg_bad;

  be_ram_array #(.DEPTH(DEPTH)) i_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(acc_ok && we_i),
    .idx_i(idx), .mask_i(mask), .wpos_i(wpos), .rword_o(rword)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      err_arg_o <= 1'b0;
      err_nxm_o <= 1'b0;
    end else begin
      err_arg_o <= req_i && arg_bad;
      err_nxm_o <= req_i && nxm_bad;
      if (req_i && !we_i) rdata_o <= acc_ok ? rext : 32'h0;
    end
  end

  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_arg_o && err_nxm_o));
  p_reject_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && dbg_i && offs_i[1:0] != 2'b00) |=> (rdata_o == 32'h0));
  p_unsup_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !dbg_i && size_i == 2'b11) |=> (rdata_o == 32'h0));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rdata_o));
endmodule

// File: tb/test_be_subword_ram.sv
module test_be_subword_ram;
  localparam int OFFS_W = 10;
  localparam int DEPTH  = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, dbg = 0;
  logic [1:0] size = 0;
  logic [OFFS_W-1:0] offs = 0;
  logic [31:0] wdata = 0, rdata;
  logic err_arg, err_nxm;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  be_subword_ram #(.OFFS_W(OFFS_W), .DEPTH(DEPTH)) i_be_subword_ram (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .dbg_i(dbg),
    .size_i(size), .offs_i(offs), .wdata_i(wdata), .rdata_o(rdata),
    .err_arg_o(err_arg), .err_nxm_o(err_nxm)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request cycle; outputs sampled at the following negedge
  task automatic acc(bit w, bit d, logic [1:0] s, int o, logic [31:0] wd);
    @(negedge clk);
    req = 1; we = w; dbg = d; size = s; offs = OFFS_W'(o); wdata = wd;
    @(negedge clk);
    req = 0; we = 0; dbg = 0;
  endtask

  task automatic rd(string tag, logic [1:0] s, int o, logic [31:0] exp);
    acc(0, 0, s, o, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic t_reset;
    chk("R8 rdata after reset", rdata, 0);
    chk("R8 flags after reset", {30'b0, err_arg, err_nxm}, 0);
    rd("R8 word 0 cleared", 2'b10, 0, 0);
    rd("R8 last word cleared", 2'b10, (DEPTH-1)*4, 0);
  endtask

  task automatic t_lanes;
    acc(1, 0, 2'b10, 0, 32'h1122_3344);
    rd("R5 word read", 2'b10, 0, 32'h1122_3344);
    rd("R2 byte 0", 2'b00, 0, 32'h11);
    rd("R2 byte 1", 2'b00, 1, 32'h22);
    rd("R2 byte 2", 2'b00, 2, 32'h33);
    rd("R2 byte 3", 2'b00, 3, 32'h44);
    rd("R3 half bit1 clear", 2'b01, 0, 32'h1122);
    rd("R3 half bit1 set", 2'b01, 2, 32'h3344);
    rd("R3 half bit0 ignored", 2'b01, 3, 32'h3344);
  endtask

  task automatic t_merge;
    acc(1, 0, 2'b00, 1, 32'hffff_ffab);
    rd("R4 byte merge", 2'b10, 0, 32'h11ab_3344);
    acc(1, 0, 2'b01, 2, 32'hdead_beef);
    rd("R4 half merge", 2'b10, 0, 32'h11ab_beef);
    acc(1, 0, 2'b10, 6, 32'hcafe_f00d);
    rd("R5 low bits ignored", 2'b10, 4, 32'hcafe_f00d);
    rd("R1 neighbour word kept", 2'b10, 0, 32'h11ab_beef);
  endtask

  task automatic t_debug;
    acc(1, 1, 2'b00, 5, 32'h0bad_0bad);
    chk("R6 arg flag", {30'b0, err_arg, err_nxm}, 32'h2);
    rd("R6 no write", 2'b10, 4, 32'hcafe_f00d);
    acc(0, 1, 2'b10, 6, 0);
    chk("R6 misaligned read zero", rdata, 0);
    acc(0, 1, 2'b10, DEPTH*4, 0);
    chk("R7 nxm flag", {30'b0, err_arg, err_nxm}, 32'h1);
    chk("R7 nxm read zero", rdata, 0);
    acc(0, 1, 2'b10, DEPTH*4+1, 0);
    chk("R7 arg over nxm", {30'b0, err_arg, err_nxm}, 32'h2);
    acc(0, 1, 2'b01, 4, 0);
    chk("R6 aligned debug is word", rdata, 32'hcafe_f00d);
    chk("R6 aligned debug no flag", {30'b0, err_arg, err_nxm}, 0);
    @(negedge clk);
    chk("R7 flag one cycle", {30'b0, err_arg, err_nxm}, 0);
  endtask

  task automatic t_odd;
    rd("R9 unsupported read", 2'b11, 0, 0);
    acc(1, 0, 2'b11, 0, 32'h5555_5555);
    rd("R9 unsupported write", 2'b10, 0, 32'h11ab_beef);
    acc(1, 0, 2'b10, DEPTH*4, 32'h7777_7777);
    chk("R10 out-of-range no flag", {30'b0, err_arg, err_nxm}, 0);
    rd("R10 out-of-range read", 2'b10, DEPTH*4, 0);
    rd("R10 aliased word kept", 2'b10, 0, 32'h11ab_beef);
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold idle", rdata, 32'h11ab_beef);
    acc(1, 0, 2'b10, 8, 32'h0);
    chk("R10 hold over write", rdata, 32'h11ab_beef);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lanes();
    t_merge();
    t_debug();
    t_odd();
    finish_run();
  end

  initial begin
    #(20 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule